// File: doc/BRIEF.md
# PTP Event Frame Timestamp Capture

This block sits on the receive byte stream of one Ethernet port. At the first byte after the start-of-frame delimiter it samples the running seconds and nanoseconds of the local time counter. It then walks the frame headers one byte per clock to decide whether the frame carries a PTP event message. The walk handles up to two VLAN tags, a stack of MPLS labels, and a PTP header that sits either directly behind the EtherType or inside UDP over IPv4 or IPv6.

For each event message it builds one 128-bit record. The record holds the sampled time, the message type, a 12-bit XOR fold of the PTP header, and the sequence identifier. The record goes into a small FIFO. Software reads records over a valid/acknowledge handshake. A record that arrives while the FIFO is full is discarded, and a sticky overflow flag is raised.

The walker is a single state machine. ST_IDLE goes to ST_PREAMBLE on a 0x55 byte, or directly to ST_MACS on the delimiter. ST_PREAMBLE goes to ST_MACS on the delimiter, and to ST_SKIP on any byte other than 0x55. ST_MACS counts twelve address bytes and then enters ST_ETYPE. ST_ETYPE branches four ways: to ST_VLAN, which returns to ST_ETYPE after the two tag bytes; to ST_MPLS, which repeats per label and goes to ST_IPVER after the bottom label; to ST_IPVER; or to ST_PTPHDR. ST_IPVER picks ST_IPV4 or ST_IPV6. Both of those lead to ST_UDP, and ST_UDP leads to ST_PTPHDR. Every rejected frame, and every completed header, ends in ST_SKIP. From any state, a low rx_dv returns the machine to ST_IDLE.

Top module: `ptp_ts_capture`

## Requirements
- R1: A record is laid out from bit 127 down as follows: 16 zero bits, the 48-bit seconds, the 32-bit nanoseconds, the 4-bit message type (the low nibble of PTP header byte 0), the 12-bit fold, and the 16-bit sequence ID (PTP header bytes 30 and 31, most significant byte first).
- R2: Preamble bytes are 0x55 and the delimiter is 0xD5. The stored time is the rtc_sec/rtc_ns value present while the first byte after 0xD5 is on rx_byte.
- R3: EtherType 0x88F7 placed directly after the 12 address bytes starts the PTP header.
- R4: A 4-byte tag with type 0x8100 or 0x88A8 is skipped before the next EtherType is read. At most MAX_VLAN (default 2) tags are accepted; a frame with one more tag produces no record.
- R5: EtherType 0x0800 (or an MPLS payload with version nibble 4) is read as IPv4. The header length comes from IHL (5 or more, in 4-byte units). The protocol byte (offset 9) must be 17, and the UDP destination port (UDP bytes 2 and 3) must be 319.
- R6: EtherType 0x86DD (or version nibble 6) is read as a fixed 40-byte IPv6 header. The next-header byte (offset 6) must be 17, and the same UDP port rule applies.
- R7: EtherType 0x8847 starts a stack of 4-byte labels. The stack ends at the label whose bottom-of-stack bit (bit 0 of the label's third byte) is set, and the IP version nibble of the next byte picks IPv4 or IPv6. A stack longer than MAX_MPLS (default 4) produces no record.
- R8: Only message types 0 to 3 produce a record. Other types, other EtherTypes, other protocols and other ports produce none.
- R9: A record is produced only if rx_dv stays high through all 34 PTP header bytes.
- R10: The fold starts at zero. Each PTP header byte at an even offset is XORed into bits 7:0, and each byte at an odd offset into bits 11:4.
- R11: rec_valid is high while the FIFO holds a record. rec_data holds the oldest record and stays stable until rec_ack is seen. Records come out in arrival order.
- R12: When the FIFO holds FIFO_DEPTH (default 4) records and no acknowledge pops in the same cycle, a new record is discarded and ovf_flag rises. The flag stays high and the stored records are unchanged.
- R13: A one-cycle pulse on ovf_rd clears ovf_flag.
- R14: After reset, rec_valid and ovf_flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Byte qualifier, high for the whole frame including the preamble |
| rx_byte | input | 8 | Received byte |
| rtc_sec | input | 48 | Running seconds of the local time counter |
| rtc_ns | input | 32 | Running nanoseconds of the local time counter |
| rec_valid | output | 1 | A record is available |
| rec_data | output | 128 | Oldest stored record |
| rec_ack | input | 1 | Pops the oldest record |
| ovf_flag | output | 1 | Sticky flag: a record was discarded because the FIFO was full |
| ovf_rd | input | 1 | Clears ovf_flag |

## Verification
The assertions assume that rx_dv drops for at least one cycle between frames, that frames carry one byte every cycle, and that the preamble contains only 0x55 bytes followed by 0xD5. The bench drives every frame as a contiguous burst with a twelve-cycle idle gap, so it stays inside these assumptions. It raises rec_ack only while a record is visible, and it pulses ovf_rd only when no frame is in flight. Random frames mix encapsulations, VLAN depths, MPLS depths, IPv4 header lengths and message types. Directed frames cover the depth limits, the truncation boundary and the full FIFO.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;

    localparam int REC_W       = 128;
    localparam int PTP_HDR_LEN = 34;

    localparam logic [7:0]  PRE_BYTE     = 8'h55;
    localparam logic [7:0]  SFD_BYTE     = 8'hD5;
    localparam logic [15:0] ET_PTP       = 16'h88F7;
    localparam logic [15:0] ET_VLAN_C    = 16'h8100;
    localparam logic [15:0] ET_VLAN_S    = 16'h88A8;
    localparam logic [15:0] ET_MPLS      = 16'h8847;
    localparam logic [15:0] ET_IP4       = 16'h0800;
    localparam logic [15:0] ET_IP6       = 16'h86DD;
    localparam logic [7:0]  IP_PROTO_UDP = 8'd17;
    localparam logic [15:0] UDP_EVT_PORT = 16'd319;
    localparam logic [3:0]  EVT_TYPE_MAX = 4'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_MACS,
        ST_ETYPE,
        ST_VLAN,
        ST_MPLS,
        ST_IPVER,
        ST_IPV4,
        ST_IPV6,
        ST_UDP,
        ST_PTPHDR,
        ST_SKIP
    } walk_state_t;

    typedef struct packed {
        logic [15:0] pad;
        logic [47:0] sec;
        logic [31:0] ns;
        logic [3:0]  mtype;
        logic [11:0] chk;
        logic [15:0] seq;
    } ts_rec_t;

endpackage

// File: rtl/ptp_hdr_walker.sv
module ptp_hdr_walker
    import ptp_cap_pkg::*;
#(
    parameter int MAX_VLAN = 2,
    parameter int MAX_MPLS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_dv,
    input  logic [7:0]  rx_byte,
    input  logic [47:0] rtc_sec,
    input  logic [31:0] rtc_ns,
    output logic        hit_o,
    output ts_rec_t     rec_o
);

    localparam int VW = $clog2(MAX_VLAN + 1);
    localparam int MW = $clog2(MAX_MPLS + 1);

    walk_state_t    state_q, state_d;
    logic [5:0]     cnt_q;
    logic [7:0]     prev_q;
    logic [15:0]    pair;
    logic [VW-1:0]  vlan_q;
    logic [MW-1:0]  mpls_q;
    logic           bos_q;
    logic [5:0]     ip4_last_q;
    logic [47:0]    sec_q;
    logic [31:0]    ns_q;
    logic [3:0]     mtype_q;
    logic [11:0]    chk_q;
    logic [15:0]    seq_q;
    logic [11:0]    fold_term;

    assign pair      = {prev_q, rx_byte};
    assign fold_term = cnt_q[0] ? {rx_byte, 4'h0} : {4'h0, rx_byte};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!rx_dv) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    state_d = (rx_byte == SFD_BYTE) ? ST_MACS : ST_PREAMBLE;
                ST_PREAMBLE:
                    if (rx_byte == SFD_BYTE)      state_d = ST_MACS;
                    else if (rx_byte != PRE_BYTE) state_d = ST_SKIP;
                ST_MACS:
                    if (cnt_q == 6'd11) state_d = ST_ETYPE;
                ST_ETYPE:
                    if (cnt_q == 6'd1) begin
                        if (pair == ET_PTP)
                            state_d = ST_PTPHDR;
                        else if ((pair == ET_VLAN_C || pair == ET_VLAN_S)
                                 && vlan_q != VW'(MAX_VLAN))
                            state_d = ST_VLAN;
                        else if (pair == ET_MPLS)
                            state_d = ST_MPLS;
                        else if (pair == ET_IP4 || pair == ET_IP6)
                            state_d = ST_IPVER;
                        else
                            state_d = ST_SKIP;
                    end
                ST_VLAN:
                    if (cnt_q == 6'd1) state_d = ST_ETYPE;
                ST_MPLS:
                    if (cnt_q == 6'd3) begin
                        if (bos_q)                              state_d = ST_IPVER;
                        else if (mpls_q == MW'(MAX_MPLS - 1))   state_d = ST_SKIP;
                    end
                ST_IPVER:
                    if (rx_byte[7:4] == 4'h4 && rx_byte[3:0] >= 4'd5) state_d = ST_IPV4;
                    else if (rx_byte[7:4] == 4'h6)                    state_d = ST_IPV6;
                    else                                              state_d = ST_SKIP;
                ST_IPV4:
                    if (cnt_q == 6'd9 && rx_byte != IP_PROTO_UDP) state_d = ST_SKIP;
                    else if (cnt_q == ip4_last_q)                 state_d = ST_UDP;
                ST_IPV6:
                    if (cnt_q == 6'd6 && rx_byte != IP_PROTO_UDP) state_d = ST_SKIP;
                    else if (cnt_q == 6'd39)                      state_d = ST_UDP;
                ST_UDP:
                    if (cnt_q == 6'd3 && pair != UDP_EVT_PORT) state_d = ST_SKIP;
                    else if (cnt_q == 6'd7)                    state_d = ST_PTPHDR;
                ST_PTPHDR:
                    if (cnt_q == 6'd0 && rx_byte[3:0] > EVT_TYPE_MAX) state_d = ST_SKIP;
                    else if (cnt_q == 6'(PTP_HDR_LEN - 1))            state_d = ST_SKIP;
                ST_SKIP:
                    state_d = ST_SKIP;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // Counters, captured fields and the record strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            prev_q     <= '0;
            vlan_q     <= '0;
            mpls_q     <= '0;
            bos_q      <= 1'b0;
            ip4_last_q <= '0;
            sec_q      <= '0;
            ns_q       <= '0;
            mtype_q    <= '0;
            chk_q      <= '0;
            seq_q      <= '0;
            hit_o      <= 1'b0;
        end else begin
            prev_q <= rx_byte;
            hit_o  <= 1'b0;

            if (state_d != state_q)
                cnt_q <= (state_d == ST_IPV4 || state_d == ST_IPV6) ? 6'd1 : 6'd0;
            else if (state_q == ST_MPLS && cnt_q == 6'd3)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 6'd1;

            if (state_q == ST_IDLE) begin
                vlan_q <= '0;
                mpls_q <= '0;
            end
            if (state_q == ST_MACS && cnt_q == 6'd0) begin
                sec_q <= rtc_sec;
                ns_q  <= rtc_ns;
            end
            if (state_q == ST_ETYPE && state_d == ST_VLAN)
                vlan_q <= vlan_q + 1'b1;
            if (state_q == ST_MPLS && cnt_q == 6'd2)
                bos_q <= rx_byte[0];
            if (state_q == ST_MPLS && cnt_q == 6'd3)
                mpls_q <= mpls_q + 1'b1;
            if (state_q == ST_IPVER)
                ip4_last_q <= {rx_byte[3:0], 2'b00} - 6'd1;

            if (state_q == ST_PTPHDR) begin
                if (cnt_q == 6'd0) begin
                    mtype_q <= rx_byte[3:0];
                    chk_q   <= fold_term;
                end else begin
                    chk_q   <= chk_q ^ fold_term;
                end
                if (cnt_q == 6'd31)
                    seq_q <= pair;
                if (cnt_q == 6'(PTP_HDR_LEN - 1) && rx_dv)
                    hit_o <= 1'b1;
            end
        end
    end

    assign rec_o = {16'h0000, sec_q, ns_q, mtype_q, chk_q, seq_q};

endmodule

// File: rtl/ptp_rec_fifo.sv
module ptp_rec_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_ack,
    output logic                         rd_valid,
    output logic [W-1:0]                 rd_data,
    input  logic                         ovf_clr,
    output logic                         ovf,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [LW-1:0] cnt_q;
    logic          pop, push, drop;

    assign pop  = rd_ack && (cnt_q != '0);
    assign push = wr_en && ((cnt_q != LW'(DEPTH)) || pop);
    assign drop = wr_en && !push;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + LW'(push) - LW'(pop);
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assign rd_valid = (cnt_q != '0);
    assign rd_data  = mem[rd_q];
    assign level    = cnt_q;

endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
    import ptp_cap_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int MAX_VLAN   = 2,
    parameter int MAX_MPLS   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_dv,
    input  logic [7:0]   rx_byte,
    input  logic [47:0]  rtc_sec,
    input  logic [31:0]  rtc_ns,
    output logic         rec_valid,
    output logic [127:0] rec_data,
    input  logic         rec_ack,
    output logic         ovf_flag,
    input  logic         ovf_rd
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             walk_hit;
    ts_rec_t          walk_rec;
    logic [LVL_W-1:0] fifo_level;

    ptp_hdr_walker #(
        .MAX_VLAN (MAX_VLAN),
        .MAX_MPLS (MAX_MPLS)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_dv   (rx_dv),
        .rx_byte (rx_byte),
        .rtc_sec (rtc_sec),
        .rtc_ns  (rtc_ns),
        .hit_o   (walk_hit),
        .rec_o   (walk_rec)
    );

    ptp_rec_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (REC_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (walk_hit),
        .wr_data  (walk_rec),
        .rd_ack   (rec_ack),
        .rd_valid (rec_valid),
        .rd_data  (rec_data),
        .ovf_clr  (ovf_rd),
        .ovf      (ovf_flag),
        .level    (fifo_level)
    );

endmodule

// File: rtl/ptp_ts_capture_chk.sv
module ptp_ts_capture_chk
    import ptp_cap_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rx_dv,
    input logic                        walk_hit,
    input ts_rec_t                     walk_rec,
    input logic                        rec_valid,
    input logic [127:0]                rec_data,
    input logic                        rec_ack,
    input logic                        ovf_flag,
    input logic                        ovf_rd,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_level
);

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_data[127:112] == 16'h0000)); // R1

    AST_HIT_EVENT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_hit |-> (walk_rec.mtype <= EVT_TYPE_MAX)); // R8

    AST_HIT_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        walk_hit |-> $past(rx_dv)); // R9

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ack) |=> (rec_valid && $stable(rec_data))); // R11

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_rd) |=> ovf_flag); // R12

    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(fifo_level) == DEPTH)); // R12

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= DEPTH); // R12

endmodule

bind ptp_ts_capture ptp_ts_capture_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .walk_hit   (walk_hit),
    .walk_rec   (walk_rec),
    .rec_valid  (rec_valid),
    .rec_data   (rec_data),
    .rec_ack    (rec_ack),
    .ovf_flag   (ovf_flag),
    .ovf_rd     (ovf_rd),
    .fifo_level (fifo_level)
);

// File: tb/tb_ptp_ts_capture.sv
`timescale 1ns/1ps
module tb_ptp_ts_capture;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_dv = 1'b0;
    logic [7:0]   rx_byte = 8'h00;
    logic [47:0]  rtc_sec = '0;
    logic [31:0]  rtc_ns = '0;
    logic         rec_valid;
    logic [127:0] rec_data;
    logic         rec_ack = 1'b0;
    logic         ovf_flag;
    logic         ovf_rd = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0]   fq[$];
    logic [11:0]  fold;
    logic [127:0] expq[$];

    always #2.5 clk = ~clk;

    ptp_ts_capture dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dv     (rx_dv),
        .rx_byte   (rx_byte),
        .rtc_sec   (rtc_sec),
        .rtc_ns    (rtc_ns),
        .rec_valid (rec_valid),
        .rec_data  (rec_data),
        .rec_ack   (rec_ack),
        .ovf_flag  (ovf_flag),
        .ovf_rd    (ovf_rd)
    );

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: expected record layout
    function automatic logic [127:0] make_rec(logic [47:0] s, logic [31:0] n,
                                              logic [3:0] mt, logic [11:0] ck, logic [15:0] sq);
        return {16'h0000, s, n, mt, ck, sq};
    endfunction

    task automatic pb(logic [7:0] b);
        fq.push_back(b);
    endtask

    // R10: fold of PTP header bytes by offset parity
    task automatic ph(logic [7:0] b, int idx);
        fq.push_back(b);
        fold = fold ^ (idx[0] ? {b, 4'h0} : {4'h0, b});
    endtask

    task automatic build(int nv, int nm, int ipv, int ihl, logic [7:0] proto,
                         logic [15:0] dport, logic [3:0] mt, logic [15:0] seq);
        fq.delete();
        fold = 12'h000;
        for (int i = 0; i < 12; i++) pb(8'($urandom));
        for (int i = 0; i < nv; i++) begin
            if ($urandom % 2 == 0) begin pb(8'h81); pb(8'h00); end
            else begin pb(8'h88); pb(8'hA8); end
            pb(8'($urandom)); pb(8'($urandom));
        end
        if (nm > 0) begin
            pb(8'h88); pb(8'h47);
            for (int i = 0; i < nm; i++) begin
                pb(8'($urandom)); pb(8'($urandom));
                pb({7'($urandom), (i == nm - 1)});
                pb(8'($urandom));
            end
        end else if (ipv == 0) begin pb(8'h88); pb(8'hF7); end
        else if (ipv == 4) begin pb(8'h08); pb(8'h00); end
        else begin pb(8'h86); pb(8'hDD); end
        if (ipv == 4) begin
            pb({4'h4, 4'(ihl)});
            for (int i = 1; i < ihl * 4; i++) pb((i == 9) ? proto : 8'($urandom));
        end else if (ipv == 6) begin
            pb({4'h6, 4'($urandom)});
            for (int i = 1; i < 40; i++) pb((i == 6) ? proto : 8'($urandom));
        end
        if (ipv != 0) begin
            pb(8'($urandom)); pb(8'($urandom));
            pb(dport[15:8]); pb(dport[7:0]);
            for (int i = 0; i < 4; i++) pb(8'($urandom));
        end
        for (int i = 0; i < 34; i++) begin
            logic [7:0] b;
            if (i == 0)       b = {4'($urandom), mt};
            else if (i == 30) b = seq[15:8];
            else if (i == 31) b = seq[7:0];
            else              b = 8'($urandom);
            ph(b, i);
        end
        for (int i = 0; i < 6; i++) pb(8'($urandom));
    endtask

    // R2: time present while the first byte after 0xD5 is driven
    task automatic send(int nbytes, output logic [47:0] s, output logic [31:0] n);
        for (int i = 0; i < 8 + nbytes; i++) begin
            @(negedge clk);
            rx_dv   = 1'b1;
            rx_byte = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : fq[i-8];
            rtc_ns  = rtc_ns + 32'd5;
            if (i == 8) begin s = rtc_sec; n = rtc_ns; end
        end
        @(negedge clk);
        rx_dv   = 1'b0;
        rx_byte = 8'h00;
        repeat (12) @(negedge clk);
    endtask

    task automatic expect_rec(logic [127:0] e, string req);
        int w = 0;
        while (!rec_valid && w < 50) begin @(negedge clk); w++; end
        check(rec_valid === 1'b1, req, 128'(rec_valid), 128'd1);
        check(rec_data === e, req, rec_data, e);
        rec_ack = 1'b1;
        @(negedge clk);
        rec_ack = 1'b0;
    endtask

    task automatic expect_empty(string req);
        check(rec_valid === 1'b0, req, 128'(rec_valid), 128'd0);
    endtask

    task automatic run(int nv, int nm, int ipv, int ihl, int proto, int dport,
                       int mt, int seq, int cut, bit good, bit drain, string req);
        logic [47:0]  s;
        logic [31:0]  n;
        logic [127:0] e;
        build(nv, nm, ipv, ihl, 8'(proto), 16'(dport), 4'(mt), 16'(seq));
        rtc_sec = {16'($urandom), 32'($urandom)};
        send(fq.size() - cut, s, n);
        e = make_rec(s, n, 4'(mt), fold, 16'(seq));
        if (good) begin
            if (drain) expect_rec(e, req);
            else       expq.push_back(e);
        end else begin
            expect_empty(req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R11 actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd1588);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        check(rec_valid === 1'b0, "R14 valid", 128'(rec_valid), 128'd0);
        check(ovf_flag === 1'b0, "R14 ovf", 128'(ovf_flag), 128'd0);

        // R3 R2 R1 R10 plain layer-2
        run(0, 0, 0, 5, 17, 319, 0, 16'h1234, 0, 1, 1, "R3 L2");
        // R4 VLAN depths
        run(1, 0, 0, 5, 17, 319, 1, 16'hBEEF, 0, 1, 1, "R4 one tag");
        run(2, 0, 4, 5, 17, 319, 2, 16'h0102, 0, 1, 1, "R4 two tags");
        run(3, 0, 0, 5, 17, 319, 0, 16'h0003, 0, 0, 1, "R4 three tags");
        // R5 IPv4 variants
        run(0, 0, 4, 5, 17, 319, 3, 16'h4444, 0, 1, 1, "R5 ihl5");
        run(0, 0, 4, 7, 17, 319, 0, 16'h4747, 0, 1, 1, "R5 ihl7");
        run(0, 0, 4, 5, 17, 320, 0, 16'h0005, 0, 0, 1, "R5 port320");
        run(0, 0, 4, 5, 6, 319, 0, 16'h0006, 0, 0, 1, "R8 proto6");
        // R6 IPv6
        run(0, 0, 6, 5, 17, 319, 1, 16'h6666, 0, 1, 1, "R6 v6");
        run(0, 0, 6, 5, 59, 319, 1, 16'h6667, 0, 0, 1, "R6 nexthdr");
        // R7 MPLS stacks
        run(0, 1, 4, 5, 17, 319, 2, 16'h7001, 0, 1, 1, "R7 one label");
        run(1, 4, 6, 5, 17, 319, 0, 16'h7004, 0, 1, 1, "R7 four labels");
        run(0, 5, 4, 5, 17, 319, 0, 16'h7005, 0, 0, 1, "R7 five labels");
        // R8 general message type
        run(0, 0, 0, 5, 17, 319, 11, 16'h0008, 0, 0, 1, "R8 type11");
        // R9 truncation boundary
        run(0, 0, 0, 5, 17, 319, 0, 16'h0909, 7, 0, 1, "R9 short");
        run(0, 0, 0, 5, 17, 319, 0, 16'h0910, 6, 1, 1, "R9 exact");

        // R11 hold and order
        run(0, 0, 4, 5, 17, 319, 0, 16'hA001, 0, 1, 0, "R11");
        run(0, 0, 6, 5, 17, 319, 1, 16'hA002, 0, 1, 0, "R11");
        repeat (5) @(negedge clk);
        check(rec_valid === 1'b1 && rec_data === expq[0], "R11 hold", rec_data, expq[0]);
        while (expq.size() > 0) expect_rec(expq.pop_front(), "R11 order");
        expect_empty("R11 drained");

        // R12 overflow, R13 clear
        for (int k = 0; k < 5; k++)
            run(0, 0, 0, 5, 17, 319, k % 4, 16'hC000 + k, 0, 1, 0, "R12");
        void'(expq.pop_back());
        check(ovf_flag === 1'b1, "R12 flag", 128'(ovf_flag), 128'd1);
        while (expq.size() > 0) expect_rec(expq.pop_front(), "R12 kept");
        expect_empty("R12 dropped");
        check(ovf_flag === 1'b1, "R12 sticky", 128'(ovf_flag), 128'd1);
        ovf_rd = 1'b1;
        @(negedge clk);
        ovf_rd = 1'b0;
        @(negedge clk);
        check(ovf_flag === 1'b0, "R13 clear", 128'(ovf_flag), 128'd0);

        // R8 random mix
        for (int k = 0; k < 40; k++) begin
            int sel, ipv, nm, nv, ihl, proto, dport, mt;
            bit good;
            sel   = int'($urandom % 3);
            ipv   = (sel == 0) ? 0 : (sel == 1) ? 4 : 6;
            nm    = (ipv != 0 && $urandom % 3 == 0) ? 1 + int'($urandom % 4) : 0;
            nv    = int'($urandom % 3);
            ihl   = 5 + int'($urandom % 3);
            proto = ($urandom % 6 == 0) ? 6 : 17;
            dport = ($urandom % 6 == 0) ? 320 : 319;
            mt    = ($urandom % 5 == 0) ? 8 + int'($urandom % 8) : int'($urandom % 4);
            good  = (mt < 4) && (ipv == 0 || (proto == 17 && dport == 319));
            run(nv, nm, ipv, ihl, proto, dport, mt, int'($urandom % 65536), 0, good, 1, "R8 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule